// File: doc/BRIEF.md
# ALU with Status Flags

This block is a purely combinational integer arithmetic-logic unit with a configurable operand width (8 bits by default). Two operands enter together with a three-bit control: a negate bit and a two-bit operation select. Together these choose bitwise AND, bitwise OR, addition, subtraction or a signed less-than compare. One ripple adder serves all three arithmetic operations. When the negate bit is set, the second operand is inverted and the carry into the lowest bit is forced to one, so the adder produces `a - b` as `a + ~b + 1`.

Beside the result the block drives a dedicated zero indicator and six status flags: sign, carry, overflow, parity, nibble (auxiliary) carry and zero. A typical use is in a simple processor datapath. The zero indicator after a subtraction gives the equality test for conditional branches, and the compare result feeds a set-if-less instruction. The flags can be captured into a status register outside this block.

Top module: `alu_flagged`

## Requirements
- R1: With negate=0 and select=00 the result is `opa & opb`, and the carry, overflow and auxiliary flags are 0.
- R2: With negate=0 and select=01 the result is `opa | opb`, and the carry, overflow and auxiliary flags are 0.
- R3: With negate=0 and select=10 the result is `opa + opb` modulo 2^WIDTH, and the carry flag is the carry out of the top bit.
- R4: With negate=1 and select=10 the result is `opa - opb` modulo 2^WIDTH. The carry flag is the carry out of the top bit of `opa + ~opb + 1`, so it is 1 exactly when `opa >= opb` as unsigned numbers, including `opa == opb`.
- R5: With negate=1 and select=11, bit 0 of the result is 1 exactly when `opa < opb` as two's-complement numbers, and all other bits are 0. The decision is correct even when the internal subtraction overflows.
- R6: For the three arithmetic codes (0/10, 1/10, 1/11), the overflow flag is the carry into the top bit XOR the carry out of the top bit. Two addends of opposite sign never raise it.
- R7: For the three arithmetic codes, the auxiliary flag is the carry out of bit 3, the top of the low 4-bit nibble.
- R8: The sign flag equals the top bit of the result. The parity flag is 1 when the result holds an even number of 1 bits. Example: 0xDB + 0xAD gives result 0x88 with sign=1, carry=1, overflow=0, parity=1, aux=1, zero=0.
- R9: The `zero` output and the zero flag are both 1 exactly when every result bit is 0.
- R10: The unused codes (negate=0 with select=11, negate=1 with select=00 or 01) give a result of 0, with the carry, overflow and auxiliary flags at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| negate | input | 1 | Inverts opb and forces adder carry-in to 1 |
| op_sel | input | 2 | Operation select: 00 AND, 01 OR, 10 sum, 11 less-than |
| result | output | WIDTH | Operation result |
| zero | output | 1 | 1 when result is all zeros |
| flag_sign | output | 1 | Top bit of result |
| flag_carry | output | 1 | Carry out of the top adder bit (arithmetic codes only) |
| flag_ovf | output | 1 | Signed overflow (arithmetic codes only) |
| flag_parity | output | 1 | 1 when result has an even count of ones |
| flag_aux | output | 1 | Carry out of bit 3 (arithmetic codes only) |
| flag_zero | output | 1 | Zero flag, same meaning as `zero` |

## Verification
The block holds no state, so a fault in the carry chain shows at the ports in the same cycle the operands are applied. It appears as a wrong sum bit together with a wrong carry, auxiliary or overflow flag. A broken link at the nibble boundary or at the top bit therefore shows only for operands whose carries cross that point. For this reason the stimulus includes all-ones, the most positive value, the most negative value and zero in every pairing, as well as random values. A wrong less-than decision shows only for operand pairs whose difference overflows, so the sign-crossing pairs are the ones that catch it.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } sel_e;

    typedef enum logic [2:0] {
        KIND_AND,
        KIND_OR,
        KIND_ARITH,
        KIND_LESS,
        KIND_NONE
    } kind_e;

    typedef struct packed {
        logic sign;
        logic carry;
        logic ovf;
        logic parity;
        logic aux;
        logic zero;
    } flags_t;

    function automatic kind_e decode_kind(input logic neg, input sel_e sel);
        kind_e k;
        case ({neg, sel})
            {1'b0, SEL_AND}:  k = KIND_AND;
            {1'b0, SEL_OR}:   k = KIND_OR;
            {1'b0, SEL_SUM}:  k = KIND_ARITH;
            {1'b1, SEL_SUM}:  k = KIND_ARITH;
            {1'b1, SEL_LESS}: k = KIND_LESS;
            default:          k = KIND_NONE;
        endcase
        return k;
    endfunction

    function automatic logic kind_is_arith(input kind_e k);
        return (k == KIND_ARITH) || (k == KIND_LESS);
    endfunction

endpackage

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
    parameter int WIDTH    = 8,
    parameter int NIBBLE_W = 4
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             c_msb_in,
    output logic             c_out,
    output logic             c_nib
);
    logic [WIDTH:0] c;
    assign c[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic p;
        assign p        = x[i] ^ y[i];
        assign sum[i]   = p ^ c[i];
        assign c[i+1]   = (x[i] & y[i]) | (p & c[i]);
    end

    assign c_out    = c[WIDTH];
    assign c_msb_in = c[WIDTH-1];
    assign c_nib    = c[NIBBLE_W];

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             use_or,
    output logic [WIDTH-1:0] out
);
    always_comb begin
        if (use_or) out = x | y;
        else        out = x & y;
    end
endmodule

// File: rtl/alu_status.sv
module alu_status
    import alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] res,
    input  logic             arith_en,
    input  logic             c_out,
    input  logic             c_msb_in,
    input  logic             c_nib,
    output flags_t           flags
);
    always_comb begin
        flags.sign   = res[WIDTH-1];
        flags.parity = ~^res;
        flags.zero   = ~|res;
        flags.carry  = arith_en & c_out;
        flags.ovf    = arith_en & (c_out ^ c_msb_in);
        flags.aux    = arith_en & c_nib;
    end
endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
    import alu_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int NIBBLE_W = 4
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             negate,
    input  logic [1:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             flag_sign,
    output logic             flag_carry,
    output logic             flag_ovf,
    output logic             flag_parity,
    output logic             flag_aux,
    output logic             flag_zero
);
    localparam int MSB = WIDTH - 1;

    kind_e            kind;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] logic_out;
    logic             c_out, c_msb_in, c_nib;
    logic             less;
    flags_t           flags;

    assign kind  = decode_kind(negate, sel_e'(op_sel));
    assign b_eff = negate ? ~opb : opb;

    alu_ripple_adder #(.WIDTH(WIDTH), .NIBBLE_W(NIBBLE_W)) u_adder (
        .x(opa), .y(b_eff), .cin(negate),
        .sum(sum), .c_msb_in(c_msb_in), .c_out(c_out), .c_nib(c_nib)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .x(opa), .y(opb), .use_or(kind == KIND_OR), .out(logic_out)
    );

    // signed less: sign of difference corrected by overflow
    assign less = sum[MSB] ^ (c_out ^ c_msb_in);

    always_comb begin
        case (kind)
            KIND_AND, KIND_OR: result = logic_out;
            KIND_ARITH:        result = sum;
            KIND_LESS:         result = {{(WIDTH-1){1'b0}}, less};
            default:           result = '0;
        endcase
    end

    alu_status #(.WIDTH(WIDTH)) u_status (
        .res(result), .arith_en(kind_is_arith(kind)),
        .c_out(c_out), .c_msb_in(c_msb_in), .c_nib(c_nib), .flags(flags)
    );

    assign zero        = flags.zero;
    assign flag_sign   = flags.sign;
    assign flag_carry  = flags.carry;
    assign flag_ovf    = flags.ovf;
    assign flag_parity = flags.parity;
    assign flag_aux    = flags.aux;
    assign flag_zero   = flags.zero;

    always_comb begin
        assert_zero_R9: assert (zero == (result == '0))
            else $error("zero output disagrees with result");
        if (kind == KIND_AND || kind == KIND_OR)
            assert_logic_noarith_R1: assert (!flag_carry && !flag_ovf && !flag_aux)
                else $error("arithmetic flag set on logic op");
        if (kind == KIND_NONE)
            assert_reserved_R10: assert (result == '0 && !flag_carry && !flag_ovf && !flag_aux)
                else $error("reserved code produced output");
        if (kind == KIND_LESS)
            assert_less_shape_R5: assert (result[MSB:1] == '0)
                else $error("less-than result has upper bits");
        if (negate && op_sel == 2'b10 && opa == opb)
            assert_sub_equal_R4: assert (zero && flag_carry)
                else $error("equal subtract not zero with carry");
        if (!negate && op_sel == 2'b10 && opa[MSB] != opb[MSB])
            assert_no_overflow_R6: assert (!flag_ovf)
                else $error("overflow on mixed-sign add");
    end

endmodule

// File: tb/alu_flagged_tb.sv
`timescale 1ns/1ps
module alu_flagged_tb;

    localparam int W = 8;

    typedef struct {
        logic [W-1:0] res;
        logic         s, c, o, p, a, z;
        string        req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opa = '0, opb = '0;
    logic         negate = 1'b0;
    logic [1:0]   op_sel = 2'b00;
    logic [W-1:0] result;
    logic         zero, flag_sign, flag_carry, flag_ovf, flag_parity, flag_aux, flag_zero;

    int   n_tests  = 0;
    int   n_failed = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    alu_flagged u_dut (
        .opa(opa), .opb(opb), .negate(negate), .op_sel(op_sel),
        .result(result), .zero(zero), .flag_sign(flag_sign), .flag_carry(flag_carry),
        .flag_ovf(flag_ovf), .flag_parity(flag_parity), .flag_aux(flag_aux),
        .flag_zero(flag_zero)
    );

    function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic neg, input logic [1:0] sel);
        exp_t e;
        logic [W-1:0] bb;
        logic [W:0]   s9;
        logic [4:0]   s5;
        logic [W-1:0] s7;
        logic         arith;
        bb = neg ? ~b : b;
        s9 = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, neg};
        s5 = {1'b0, a[3:0]} + {1'b0, bb[3:0]} + {4'b0, neg};
        s7 = {1'b0, a[W-2:0]} + {1'b0, bb[W-2:0]} + {{(W-1){1'b0}}, neg};
        arith = 1'b0;
        case ({neg, sel})
            3'b000: begin e.res = a & b; e.req = "R1"; end
            3'b001: begin e.res = a | b; e.req = "R2"; end
            3'b010: begin e.res = s9[W-1:0]; e.req = "R3"; arith = 1'b1; end
            3'b110: begin e.res = a - b; e.req = "R4"; arith = 1'b1; end
            3'b111: begin
                e.res = ($signed(a) < $signed(b)) ? 8'd1 : 8'd0;
                e.req = "R5"; arith = 1'b1;
            end
            default: begin e.res = '0; e.req = "R10"; end
        endcase
        e.c = arith & s9[W];
        e.a = arith & s5[4];
        e.o = arith & (s9[W] ^ s7[W-1]);
        e.s = e.res[W-1];
        e.p = ($countones(e.res) % 2) == 0;
        e.z = (e.res == '0);
        return e;
    endfunction

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic neg, input logic [1:0] sel);
        @(negedge clk);
        opa = a; opb = b; negate = neg; op_sel = sel;
        sb_q.push_back(model(a, b, neg, sel));
    endtask

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_failed++;
            $display("FAIL %s %s actual=%h expected=%h (a=%h b=%h neg=%b sel=%b)",
                     req, what, act, exp, opa, opb, negate, op_sel);
        end
    endtask

    // monitor: pops one expected item per cycle
    always @(posedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.req, "result", result, e.res);
            chk(e.req, "carry", {7'b0, flag_carry}, {7'b0, e.c});
            chk("R6", "overflow", {7'b0, flag_ovf}, {7'b0, e.o});
            chk("R7", "aux", {7'b0, flag_aux}, {7'b0, e.a});
            chk("R8", "sign", {7'b0, flag_sign}, {7'b0, e.s});
            chk("R8", "parity", {7'b0, flag_parity}, {7'b0, e.p});
            chk("R9", "zero", {7'b0, zero}, {7'b0, e.z});
            chk("R9", "flag_zero", {7'b0, flag_zero}, {7'b0, e.z});
        end
    end

    initial begin : watchdog
        #(5.0 * 200000);
        if (!done) begin
            n_failed++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] corner [6];
        corner[0] = 8'h00; corner[1] = 8'h7F; corner[2] = 8'h80;
        corner[3] = 8'hFF; corner[4] = 8'h01; corner[5] = 8'h55;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset-state check: idle inputs give zero result, R9
        drive(8'h00, 8'h00, 1'b0, 2'b00);
        // worked flag example, R8
        drive(8'hDB, 8'hAD, 1'b0, 2'b10);
        // equality by subtract, R4
        drive(8'h3C, 8'h3C, 1'b1, 2'b10);
        // less-than across overflow, R5
        drive(8'h80, 8'h01, 1'b1, 2'b11);
        drive(8'h7F, 8'h80, 1'b1, 2'b11);
        // nibble carry boundary, R7
        drive(8'h0F, 8'h01, 1'b0, 2'b10);
        // reserved codes with nonzero operands, R10
        drive(8'hFF, 8'hFF, 1'b0, 2'b11);
        drive(8'hFF, 8'hFF, 1'b1, 2'b00);
        drive(8'hFF, 8'hFF, 1'b1, 2'b01);
        for (int code = 0; code < 8; code++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    drive(corner[i], corner[j], code[2], code[1:0]);
        for (int k = 0; k < 3000; k++)
            drive(W'($urandom), W'($urandom), 1'($urandom), 2'($urandom));
        repeat (3) @(negedge clk);
        n_tests++;
        if (sb_q.size() != 0) begin
            n_failed++;
            $display("FAIL scoreboard actual=%0d expected=0 items left", sb_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
        $finish;
    end

endmodule